// File: doc/BRIEF.md
# Backplane Clock Fallback Controller

This block supervises the clock signals of a redundant backplane timing bus. For each bus clock signal it receives a one-cycle failure pulse from an external detector. It filters the pulses through a host mask and latches the errors that pass. When a failure hits a signal that feeds the current primary clock selection, it switches the active selection over to a preprogrammed secondary value. The switch happens only once per reset, because fallback is sticky. The block raises an interrupt-style clock-error output and a system-error output. The host clears these with write-one-to-clear strobes.

A two-bit policy mode picks how fallback behaves:
- `00`: automatic switch, with the reference multiplexer bypassed.
- `01`: report only, so software performs the recovery.
- `10`: automatic switch through the multiplexer.
- `11`: A/B redundancy. Any failure of the A or B clock set triggers the switch, whatever the primary selection is. A small state machine then decides whether the device releases its bus clocks or takes over the compatibility clocks.

Signal indices: bit 0 is the network reference, bit 1 is the A set, bit 2 is the B set, and bits 3 to 7 are the five-signal legacy set. Primary select codes:
- `0000`: internal oscillator, with no monitored signals.
- `0001`: A set.
- `0010`: B set.
- `0011`: network reference.
- `0100`: legacy set.
- `0101` to `0111`: reserved, with no signals.
- `1000` to `1111`: local references, with no signals.

Top module: `clk_fallback_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge, including `act_sel`.
- R2: Outside mode `11` and before any fallback, a failure on a masked-in signal that belongs to the primary selection sets `fb_active`, `clk_err` and `sys_err` one cycle later. From then on `act_sel` shows `sec_sel`. Signal membership follows the code table above.
- R3: A failure pulse whose `sig_mask` bit is 0 sets no error bit, raises no error output and causes no fallback.
- R4: A masked-in failure on a signal outside the primary selection sets its `err_bits` bit and `clk_err` one cycle later, but leaves `fb_active` and `sys_err` low.
- R5: Outside mode `11`, primary codes `1000` to `1111`, `0000` and `0101` to `0111` never cause fallback.
- R6: Once `fb_active` is set it stays set until reset. Later failures change neither it nor the drive outputs, and `act_sel` keeps following `sec_sel` with one cycle of delay.
- R7: In mode `01`, masked-in failures are latched and raise `clk_err`, but `fb_active` and `sys_err` stay low.
- R8: `ref_bypass` is 1 one cycle after `fb_mode` is `00`, and 0 one cycle after any other mode. Modes `00` and `10` switch in the same way.
- R9: In mode `11`, a masked-in failure on the A set (bit 1) or the B set (bit 2) causes fallback regardless of the primary code. Failures on other signals do not.
- R10: If a mode-`11` fallback happens while `prim_master` is 1 and `drive_a` or `drive_b` is 1, then `drv_a_en`, `drv_b_en` and `drv_compat_en` all go to 0 one cycle later and stay there until reset.
- R11: Consider a mode-`11` fallback with `prim_master` at 0, the primary slaved to one set (`0001` or `0010`), the other set driven, and the failure including the slaved set. Then `drv_compat_en` goes to 1 one cycle later. Other mode-`11` fallbacks without `prim_master` leave the drive outputs in their normal relation.
- R12: Each 1 in `err_clr` clears that `err_bits` bit, but a new failure in the same cycle wins. `clk_err` equals the OR of the updated error bits. Any nonzero `err_clr` drops `sys_err` unless fallback fires in that cycle. Clearing never drops `fb_active`.
- R13: Before any release or takeover, `drv_a_en` and `drv_b_en` follow `drive_a` and `drive_b` one cycle later. `drv_compat_en` follows `prim_master` AND (`drive_a` OR `drive_b`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_sel | input | 4 | Primary clock select code |
| prim_master | input | 1 | Primary programming drives the bus as master, which enables compatibility clocks |
| drive_a | input | 1 | Device is programmed to drive the A set |
| drive_b | input | 1 | Device is programmed to drive the B set |
| sec_sel | input | 4 | Secondary select code used after fallback |
| fb_mode | input | 2 | Fallback policy mode |
| sig_mask | input | 8 | Per-signal enable, where 1 means failures count |
| fail_pulse | input | 8 | Per-signal failure pulses |
| err_clr | input | 8 | Write-one-to-clear strobes for the error bits |
| act_sel | output | 4 | Active clock selection |
| fb_active | output | 1 | Fallback has happened |
| ref_bypass | output | 1 | Reference multiplexer bypassed (mode `00`) |
| err_bits | output | 8 | Latched per-signal errors |
| clk_err | output | 1 | Interrupt-style clock-error output |
| sys_err | output | 1 | System-error output |
| drv_a_en | output | 1 | Enable for driving the A set |
| drv_b_en | output | 1 | Enable for driving the B set |
| drv_compat_en | output | 1 | Enable for driving the compatibility clocks |

## Verification
Directed cases pair the same failure pulse with different masks, primary codes and modes. This separates a member failure, which switches, from a masked failure, which is silent, and from a non-member failure, which reports only. It also separates local and empty codes from report-only mode and from the A/B policy. Further cases repeat failures after a switch to show stickiness. The mode-`11` cases vary master, slave and driven-set programming to tell release, compatibility takeover and no change apart. Clear strobes are issued alone and together with new failures to pin down which one takes priority. Seeded random traffic, with periodic resets, then mixes all inputs against a cycle model built from the requirements.

// File: rtl/clk_fallback_pkg.sv
package clk_fallback_pkg;
  localparam int SEL_W    = 4;
  localparam int MODE_W   = 2;
  localparam int NREF_BIT = 0;
  localparam int A_BIT    = 1;
  localparam int B_BIT    = 2;
  localparam int LEG_LO   = 3;
  localparam int LEG_N    = 5;
  localparam int NSIG     = LEG_LO + LEG_N;

  localparam logic [SEL_W-1:0] SEL_OSC  = 4'h0;
  localparam logic [SEL_W-1:0] SEL_A    = 4'h1;
  localparam logic [SEL_W-1:0] SEL_B    = 4'h2;
  localparam logic [SEL_W-1:0] SEL_NREF = 4'h3;
  localparam logic [SEL_W-1:0] SEL_LEG  = 4'h4;

  localparam logic [MODE_W-1:0] MODE_BYPASS = 2'b00;
  localparam logic [MODE_W-1:0] MODE_SOFT   = 2'b01;
  localparam logic [MODE_W-1:0] MODE_MUX    = 2'b10;
  localparam logic [MODE_W-1:0] MODE_AB     = 2'b11;

  typedef enum logic [1:0] {
    DRV_NORMAL   = 2'd0,
    DRV_RELEASED = 2'd1,
    DRV_COMPAT   = 2'd2
  } drv_state_e;
endpackage

// File: rtl/fb_member_decode.sv
module fb_member_decode
  import clk_fallback_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [MODE_W-1:0] mode,
  output logic [NSIG-1:0]   members
);
  logic [NSIG-1:0] leg_mask;

  genvar g;
  generate
    for (g = 0; g < NSIG; g++) begin : g_leg
      assign leg_mask[g] = (g >= LEG_LO) && (g < LEG_LO + LEG_N);
    end
  endgenerate

  always_comb begin
    members = '0;
    if (mode == MODE_AB) begin
      members[A_BIT] = 1'b1;
      members[B_BIT] = 1'b1;
    end else if (!sel[SEL_W-1]) begin
      unique case (sel)
        SEL_A:    members[A_BIT]    = 1'b1;
        SEL_B:    members[B_BIT]    = 1'b1;
        SEL_NREF: members[NREF_BIT] = 1'b1;
        SEL_LEG:  members           = leg_mask;
        default:  members           = '0;
      endcase
    end
  end
endmodule

// File: rtl/fb_err_latch.sv
module fb_err_latch
  import clk_fallback_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSIG-1:0] hits,
  input  logic [NSIG-1:0] clr,
  input  logic            fb_hit,
  output logic [NSIG-1:0] err_q,
  output logic            clk_err_q,
  output logic            sys_err_q
);
  logic [NSIG-1:0] err_n;

  always_comb err_n = (err_q & ~clr) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= '0;
      clk_err_q <= 1'b0;
      sys_err_q <= 1'b0;
    end else begin
      err_q     <= err_n;
      clk_err_q <= |err_n;
      sys_err_q <= fb_hit | (sys_err_q & ~(|clr));
    end
  end
endmodule

// File: rtl/fb_compat_fsm.sv
module fb_compat_fsm
  import clk_fallback_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fb_hit,
  input  logic ab_mode,
  input  logic master,
  input  logic drive_a,
  input  logic drive_b,
  input  logic slave_a,
  input  logic slave_b,
  input  logic fail_a,
  input  logic fail_b,
  output logic drv_a_en,
  output logic drv_b_en,
  output logic drv_compat_en
);
  drv_state_e st_q, st_n;
  logic       take_compat;

  always_comb begin
    take_compat = !master && ((slave_a && fail_a && drive_b) ||
                              (slave_b && fail_b && drive_a));
    st_n = st_q;
    if (st_q == DRV_NORMAL && fb_hit && ab_mode) begin
      if (master && (drive_a || drive_b)) st_n = DRV_RELEASED;
      else if (take_compat)               st_n = DRV_COMPAT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= DRV_NORMAL;
      drv_a_en      <= 1'b0;
      drv_b_en      <= 1'b0;
      drv_compat_en <= 1'b0;
    end else begin
      st_q <= st_n;
      unique case (st_n)
        DRV_RELEASED: begin
          drv_a_en      <= 1'b0;
          drv_b_en      <= 1'b0;
          drv_compat_en <= 1'b0;
        end
        DRV_COMPAT: begin
          drv_a_en      <= drive_a;
          drv_b_en      <= drive_b;
          drv_compat_en <= 1'b1;
        end
        default: begin
          drv_a_en      <= drive_a;
          drv_b_en      <= drive_b;
          drv_compat_en <= master & (drive_a | drive_b);
        end
      endcase
    end
  end
endmodule

// File: rtl/clk_fallback_ctrl.sv
module clk_fallback_ctrl
  import clk_fallback_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  prim_sel,
  input  logic              prim_master,
  input  logic              drive_a,
  input  logic              drive_b,
  input  logic [SEL_W-1:0]  sec_sel,
  input  logic [MODE_W-1:0] fb_mode,
  input  logic [NSIG-1:0]   sig_mask,
  input  logic [NSIG-1:0]   fail_pulse,
  input  logic [NSIG-1:0]   err_clr,
  output logic [SEL_W-1:0]  act_sel,
  output logic              fb_active,
  output logic              ref_bypass,
  output logic [NSIG-1:0]   err_bits,
  output logic              clk_err,
  output logic              sys_err,
  output logic              drv_a_en,
  output logic              drv_b_en,
  output logic              drv_compat_en
);
  logic [NSIG-1:0] members;
  logic [NSIG-1:0] hits;
  logic            fb_hit;

  fb_member_decode u_dec (
    .sel     (prim_sel),
    .mode    (fb_mode),
    .members (members)
  );

  assign hits   = fail_pulse & sig_mask;
  assign fb_hit = !fb_active && (fb_mode != MODE_SOFT) && |(hits & members);

  fb_err_latch u_err (
    .clk       (clk),
    .rst       (rst),
    .hits      (hits),
    .clr       (err_clr),
    .fb_hit    (fb_hit),
    .err_q     (err_bits),
    .clk_err_q (clk_err),
    .sys_err_q (sys_err)
  );

  fb_compat_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .fb_hit        (fb_hit),
    .ab_mode       (fb_mode == MODE_AB),
    .master        (prim_master),
    .drive_a       (drive_a),
    .drive_b       (drive_b),
    .slave_a       (prim_sel == SEL_A),
    .slave_b       (prim_sel == SEL_B),
    .fail_a        (hits[A_BIT]),
    .fail_b        (hits[B_BIT]),
    .drv_a_en      (drv_a_en),
    .drv_b_en      (drv_b_en),
    .drv_compat_en (drv_compat_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_active  <= 1'b0;
      act_sel    <= '0;
      ref_bypass <= 1'b0;
    end else begin
      fb_active  <= fb_active | fb_hit;
      act_sel    <= (fb_active | fb_hit) ? sec_sel : prim_sel;
      ref_bypass <= (fb_mode == MODE_BYPASS);
    end
  end
endmodule

// File: rtl/clk_fallback_chk.sv
module clk_fallback_chk
  import clk_fallback_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  prim_sel,
  input logic [MODE_W-1:0] fb_mode,
  input logic [NSIG-1:0]   sig_mask,
  input logic [NSIG-1:0]   fail_pulse,
  input logic              fb_active,
  input logic [NSIG-1:0]   err_bits,
  input logic              clk_err,
  input logic              sys_err
);
  // R3
  masked_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> ((err_bits & ~$past(err_bits) & ~$past(fail_pulse & sig_mask)) == '0));

  // R6
  sticky_fb_chk: assert property (@(posedge clk) disable iff (rst)
    fb_active |=> fb_active);

  // R7
  soft_no_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_mode == MODE_SOFT && !fb_active) |=> !fb_active);

  // R5
  local_no_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_mode != MODE_AB && prim_sel[SEL_W-1] && !fb_active) |=> !fb_active);

  // R2
  switch_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_active) |-> (sys_err && clk_err));
endmodule

bind clk_fallback_ctrl clk_fallback_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .prim_sel   (prim_sel),
  .fb_mode    (fb_mode),
  .sig_mask   (sig_mask),
  .fail_pulse (fail_pulse),
  .fb_active  (fb_active),
  .err_bits   (err_bits),
  .clk_err    (clk_err),
  .sys_err    (sys_err)
);

// File: tb/clk_fallback_ctrl_tb.sv
module clk_fallback_ctrl_tb;
  import clk_fallback_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] prim_sel = '0, sec_sel = '0;
  logic prim_master = 0, drive_a = 0, drive_b = 0;
  logic [1:0] fb_mode = 2'b10;
  logic [NSIG-1:0] sig_mask = '0, fail_pulse = '0, err_clr = '0;
  logic [3:0] act_sel;
  logic fb_active, ref_bypass, clk_err, sys_err, drv_a_en, drv_b_en, drv_compat_en;
  logic [NSIG-1:0] err_bits;

  int checks = 0, errors = 0;

  // model state
  logic [3:0] m_sel;
  logic m_fb, m_byp, m_clk, m_sys, m_a, m_b, m_c;
  logic [NSIG-1:0] m_err;
  int m_st;  // 0 normal, 1 released, 2 compat

  always #2.5 clk = ~clk;

  clk_fallback_ctrl u_dut (
    .clk(clk), .rst(rst), .prim_sel(prim_sel), .prim_master(prim_master),
    .drive_a(drive_a), .drive_b(drive_b), .sec_sel(sec_sel), .fb_mode(fb_mode),
    .sig_mask(sig_mask), .fail_pulse(fail_pulse), .err_clr(err_clr),
    .act_sel(act_sel), .fb_active(fb_active), .ref_bypass(ref_bypass),
    .err_bits(err_bits), .clk_err(clk_err), .sys_err(sys_err),
    .drv_a_en(drv_a_en), .drv_b_en(drv_b_en), .drv_compat_en(drv_compat_en)
  );

  function automatic logic [NSIG-1:0] member_of(input logic [3:0] s, input logic [1:0] m);
    logic [NSIG-1:0] r = '0;
    if (m == 2'b11) begin r[1] = 1; r[2] = 1; end
    else case (s)
      4'h1: r[1] = 1;
      4'h2: r[2] = 1;
      4'h3: r[0] = 1;
      4'h4: r = 8'hF8;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NSIG-1:0] hits;
    logic hit;
    if (rst) begin
      m_sel = 0; m_fb = 0; m_byp = 0; m_clk = 0; m_sys = 0;
      m_err = 0; m_st = 0; m_a = 0; m_b = 0; m_c = 0;
      return;
    end
    hits = fail_pulse & sig_mask;
    hit = !m_fb && fb_mode != 2'b01 && ((hits & member_of(prim_sel, fb_mode)) != 0);
    m_err = (m_err & ~err_clr) | hits;
    m_clk = |m_err;
    m_sys = hit | (m_sys & ~(|err_clr));
    if (m_st == 0 && hit && fb_mode == 2'b11) begin
      if (prim_master && (drive_a || drive_b)) m_st = 1;
      else if (!prim_master && ((prim_sel == 4'h1 && hits[1] && drive_b) ||
                                (prim_sel == 4'h2 && hits[2] && drive_a))) m_st = 2;
    end
    m_fb = m_fb | hit;
    m_sel = m_fb ? sec_sel : prim_sel;
    m_byp = (fb_mode == 2'b00);
    case (m_st)
      1: begin m_a = 0; m_b = 0; m_c = 0; end
      2: begin m_a = drive_a; m_b = drive_b; m_c = 1; end
      default: begin m_a = drive_a; m_b = drive_b; m_c = prim_master & (drive_a | drive_b); end
    endcase
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    chk(tag, "act_sel", act_sel, m_sel);
    chk(tag, "fb_active", fb_active, m_fb);
    chk(tag, "ref_bypass", ref_bypass, m_byp);
    chk(tag, "err_bits", err_bits, m_err);
    chk(tag, "clk_err", clk_err, m_clk);
    chk(tag, "sys_err", sys_err, m_sys);
    chk(tag, "drv_a_en", drv_a_en, m_a);
    chk(tag, "drv_b_en", drv_b_en, m_b);
    chk(tag, "drv_compat_en", drv_compat_en, m_c);
    fail_pulse = '0;
    err_clr = '0;
  endtask

  task automatic do_reset();
    rst = 1; tick("R1"); rst = 0;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    do_reset();
    chk("R1", "fb_active after reset", fb_active, 0);
    chk("R1", "act_sel after reset", act_sel, 0);

    // R2: network reference member failure
    fb_mode = 2'b10; prim_sel = 4'h3; sec_sel = 4'h4; sig_mask = 8'h01;
    tick("R2");
    fail_pulse = 8'h01; tick("R2");
    chk("R2", "act_sel switched", act_sel, 4'h4);
    tick("R2");

    // R3: masked failure silent
    do_reset();
    sig_mask = 8'hFE; fail_pulse = 8'h01; tick("R3");
    chk("R3", "err_bits masked", err_bits, 0);
    tick("R3");

    // R4 then R2: legacy primary, non-member failure then member
    do_reset();
    prim_sel = 4'h4; sig_mask = 8'h3A; fail_pulse = 8'h02; tick("R4");
    chk("R4", "no fallback", fb_active, 0);
    chk("R4", "err bit A", err_bits, 8'h02);
    fail_pulse = 8'h10; tick("R2");
    chk("R2", "legacy fallback", fb_active, 1);

    // R6: sticky
    fail_pulse = 8'hFF; sec_sel = 4'h9; tick("R6");
    chk("R6", "act_sel follows sec", act_sel, 4'h9);
    prim_sel = 4'h3; tick("R6");

    // R5: local and empty codes
    do_reset();
    sig_mask = 8'hFF;
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 4) continue;
      prim_sel = c[3:0]; fail_pulse = 8'hFF; tick("R5");
    end
    chk("R5", "no fallback on local codes", fb_active, 0);

    // R7: software mode
    do_reset();
    fb_mode = 2'b01; prim_sel = 4'h3; fail_pulse = 8'hFF; tick("R7");
    chk("R7", "soft no switch", fb_active, 0);
    chk("R7", "soft clk_err", clk_err, 1);

    // R8: bypass mode
    do_reset();
    fb_mode = 2'b00; tick("R8");
    chk("R8", "bypass flag", ref_bypass, 1);
    fail_pulse = 8'h01; tick("R8");
    chk("R8", "bypass mode switches", fb_active, 1);

    // R9: A/B mode ignores network ref, reacts to B
    do_reset();
    fb_mode = 2'b11; prim_sel = 4'h3; fail_pulse = 8'h01; tick("R9");
    chk("R9", "nref ignored in mode 11", fb_active, 0);
    fail_pulse = 8'h04; tick("R9");
    chk("R9", "B set fallback", fb_active, 1);

    // R13, R10: master drives A, failure releases
    do_reset();
    prim_master = 1; drive_a = 1; prim_sel = 4'h1; tick("R13");
    chk("R13", "compat when master", drv_compat_en, 1);
    fail_pulse = 8'h04; tick("R10");
    chk("R10", "released a", drv_a_en, 0);
    chk("R10", "released compat", drv_compat_en, 0);
    tick("R10");

    // R11: slaved to A, drives B, failure on A
    do_reset();
    prim_master = 0; drive_a = 0; drive_b = 1; prim_sel = 4'h1; tick("R13");
    fail_pulse = 8'h02; tick("R11");
    chk("R11", "compat taken", drv_compat_en, 1);
    chk("R11", "still drives B", drv_b_en, 1);
    do_reset();
    fail_pulse = 8'h04; tick("R11");
    chk("R11", "other set failure no takeover", drv_compat_en, 0);

    // R12: clears
    err_clr = 8'hFF; tick("R12");
    chk("R12", "clk_err cleared", clk_err, 0);
    chk("R12", "sys_err cleared", sys_err, 0);
    chk("R12", "fb kept", fb_active, 1);
    fail_pulse = 8'h06; tick("R12");
    err_clr = 8'h02; fail_pulse = 8'h02; tick("R12");
    chk("R12", "set wins over clear", err_bits, 8'h06);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 50 == 0) do_reset();
      fb_mode = 2'($urandom);
      if ($urandom % 8 == 0) prim_sel = 4'($urandom);
      sec_sel = 4'($urandom);
      prim_master = 1'($urandom); drive_a = 1'($urandom); drive_b = 1'($urandom);
      sig_mask = NSIG'($urandom);
      fail_pulse = ($urandom % 6 == 0) ? NSIG'(1 << ($urandom % NSIG)) : '0;
      err_clr = ($urandom % 10 == 0) ? NSIG'($urandom) : '0;
      tick("R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule